// File: doc/BRIEF.md
# Toggle-Cleared Watchdog Timer

This block watches a heartbeat line that a processor toggles while its software is alive. Each toggle, up or down, restarts an idle counter. If the heartbeat holds still for a full timeout, the active-low watchdog output drops. It stays low until the next toggle or until the system reset clears the counter. The output is meant to feed an interrupt line, or to be wired back into a manual-reset input. The block never raises reset on its own.

The heartbeat passes through a flop synchroniser. A change between the last two synchronised samples counts as a toggle, so any level that lasts one clock period is seen. The counter stays at zero while the system reset from the reset generator is active. It also stays at zero while the enable input is low. The enable models a heartbeat pin left floating. With the enable low, no timeout can occur and the output falls only on low supply.

A low-supply flag pulls the output low at once, whatever the counter holds. When the flag clears, the output rises in that same cycle, unless a timeout is pending. The timeout length, in clock ticks, is a parameter.

Top module: `heartbeat_watchdog`

## Requirements
- R1: With the block enabled and no heartbeat toggle, `wdo_n` goes low exactly `TIMEOUT_TICKS` rising clock edges after the idle counter was last cleared.
- R2: A rising heartbeat level change that is first present before edge k clears the counter at edge k+2. The output is therefore high again after edge k+2.
- R3: A falling heartbeat level change clears the counter with the same two-edge latency as R2.
- R4: While `sys_rst` is high, the counter is held at zero. The timeout count starts at the first edge after `sys_rst` falls.
- R5: Once timed out, `wdo_n` stays low until a heartbeat toggle or `sys_rst` clears the counter.
- R6: `wdo_n` is low whenever `low_supply` is high, whether or not a timeout is pending.
- R7: When `low_supply` falls and no timeout is pending, `wdo_n` rises in the same cycle, with no register in the path.
- R8: While `wd_en` is low, no timeout is flagged, and `wdo_n` follows only `low_supply`, active low.
- R9: While `wd_en` is low, the counter is cleared. After `wd_en` returns high, a full `TIMEOUT_TICKS` must pass before a timeout.
- R10: The counter saturates at `TIMEOUT_TICKS` and never wraps, so a long silence keeps `wdo_n` low.
- R11: A heartbeat pulse one clock period wide is detected and clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counting is in its rising edges |
| sys_rst | input | 1 | Active-high reset from the reset generator; holds the counter clear |
| hb_in | input | 1 | Processor heartbeat, asynchronous to `clk` |
| wd_en | input | 1 | High enables timeout detection; low models a floating heartbeat pin |
| low_supply | input | 1 | High while the supply is below its threshold |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The bench builds the block with `TIMEOUT_TICKS` set to 12 and `SYNC_STAGES` left at 2. With that timeout, a run reaches saturation many times over, and it can toggle at intervals just under and just over the limit. It also leaves room for a one-cycle heartbeat pulse placed two ticks before expiry. With two synchroniser stages, the fixed two-edge latency from a heartbeat change to a cleared counter falls at a known cycle, so the bench can sample there.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Why the watchdog output is in its present state.
    typedef enum logic [1:0] {
        WDO_CAUSE_NONE    = 2'd0,
        WDO_CAUSE_EXPIRED = 2'd1,
        WDO_CAUSE_LOWLINE = 2'd2
    } wdo_cause_e;

    // Per-cycle control decision for the idle counter.
    typedef enum logic [1:0] {
        CNT_OP_CLEAR = 2'd0,
        CNT_OP_STEP  = 2'd1,
        CNT_OP_HOLD  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic hb_raw,
    output logic hb_toggle
);

    // Stages 0..SYNC_STAGES-1 form the synchroniser.
    // Stage SYNC_STAGES keeps the previous synchronised sample.
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = hb_raw;
        for (int i = 1; i < CHAIN_W; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hb_toggle = st_q.chain[SYNC_STAGES-1] ^ st_q.chain[SYNC_STAGES];

    generate
        if (SYNC_STAGES >= 2) begin : g_chk
            // A difference about to move into the compared pair must show up as a toggle.
            p_pulse_seen_r11: assert property (@(posedge clk) disable iff (sys_rst)
                (st_q.chain[SYNC_STAGES-2] != st_q.chain[SYNC_STAGES-1]) |=> hb_toggle);
        end
    endgenerate

endmodule

// File: rtl/idle_counter.sv
module idle_counter
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic run_en,
    input  logic restart,
    output logic expired
);

    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_op_e    op;

    always_comb begin
        if (sys_rst || !run_en || restart) begin
            op = CNT_OP_CLEAR;
        end else if (st_q.cnt != LIMIT) begin
            op = CNT_OP_STEP;
        end else begin
            op = CNT_OP_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            CNT_OP_CLEAR: st_d.cnt = '0;
            CNT_OP_STEP:  st_d.cnt = st_q.cnt + ONE;
            default:      st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign expired = (st_q.cnt == LIMIT);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (sys_rst)
        st_q.cnt <= LIMIT);
    p_saturate_r10: assert property (@(posedge clk) disable iff (sys_rst)
        (expired && run_en && !restart) |=> expired);
    p_fresh_after_reset_r4: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(sys_rst) |-> (st_q.cnt == '0));
    p_toggle_clears_r2: assert property (@(posedge clk) disable iff (sys_rst)
        restart |=> (st_q.cnt == '0));
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (sys_rst)
        !run_en |=> (st_q.cnt == '0));
    p_counts_up_r1: assert property (@(posedge clk) disable iff (sys_rst)
        (run_en && !restart && !expired) |=> (st_q.cnt == $past(st_q.cnt) + ONE));

endmodule

// File: rtl/wdo_stage.sv
module wdo_stage
    import wdt_pkg::*;
(
    input  logic run_en,
    input  logic expired,
    input  logic low_supply,
    output logic wdo_n
);

    wdo_cause_e cause;

    // Low supply wins over a timeout; the path is combinational so release is immediate.
    always_comb begin
        if (low_supply) begin
            cause = WDO_CAUSE_LOWLINE;
        end else if (run_en && expired) begin
            cause = WDO_CAUSE_EXPIRED;
        end else begin
            cause = WDO_CAUSE_NONE;
        end
    end

    assign wdo_n = (cause == WDO_CAUSE_NONE);

endmodule

// File: rtl/heartbeat_watchdog.sv
module heartbeat_watchdog #(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic hb_in,
    input  logic wd_en,
    input  logic low_supply,
    output logic wdo_n
);

    logic hb_toggle;
    logic expired;

    hb_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .hb_raw    (hb_in),
        .hb_toggle (hb_toggle)
    );

    idle_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk     (clk),
        .sys_rst (sys_rst),
        .run_en  (wd_en),
        .restart (hb_toggle),
        .expired (expired)
    );

    wdo_stage u_out (
        .run_en     (wd_en),
        .expired    (expired),
        .low_supply (low_supply),
        .wdo_n      (wdo_n)
    );

    p_lowline_forces_r6: assert property (@(posedge clk) disable iff (sys_rst)
        low_supply |-> !wdo_n);
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (sys_rst)
        (!wd_en && !low_supply) |-> wdo_n);
    p_sticky_r5: assert property (@(posedge clk) disable iff (sys_rst)
        (!wdo_n && !low_supply && wd_en && !hb_toggle) |=> (!wdo_n || !wd_en));

endmodule

// File: tb/sim_heartbeat_watchdog.sv
module sim_heartbeat_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 12;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic hb_in = 1'b0;
    logic wd_en = 1'b1;
    logic low_supply = 1'b0;
    logic wdo_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R4";

    // Behavioural reference: ticks since last clear, plus heartbeat sample history.
    int idle = 0;
    int h1 = 0, h2 = 0, h3 = 0;
    bit done = 1'b0;

    heartbeat_watchdog #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .hb_in      (hb_in),
        .wd_en      (wd_en),
        .low_supply (low_supply),
        .wdo_n      (wdo_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit clr;
        cycles++;
        clr = sys_rst || !wd_en || (h2 != h3);
        if (clr) idle = 0;
        else if (idle < T) idle++;
        h3 = h2; h2 = h1; h1 = int'(hb_in);
    end

    function automatic logic model_wdo();
        return !(low_supply || (wd_en && idle >= T));
    endfunction

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            checks++;
            if (wdo_n !== model_wdo()) begin
                errors++;
                $display("FAIL %s cycle %0d: wdo_n=%b expected %b", cur_req, cycles, wdo_n, model_wdo());
            end
        end
    end

    task automatic check(input logic exp, input string req);
        checks++;
        if (wdo_n !== exp) begin
            errors++;
            $display("FAIL %s: wdo_n=%b expected %b", req, wdo_n, exp);
        end
    endtask

    // Advance n rising edges, then settle just after the next falling edge.
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        cur_req = "R4";
        wait_cyc(6);
        check(1'b1, "R4 during reset");
        wait_cyc(T + 4);
        check(1'b1, "R4 reset holds counter");
        sys_rst = 1'b0;
        cur_req = "R1";
        wait_cyc(T - 1);
        check(1'b1, "R1 one tick before timeout");
        wait_cyc(1);
        check(1'b0, "R1 timeout reached");

        cur_req = "R10";
        wait_cyc(3 * T);
        check(1'b0, "R10 saturated, no wrap");

        cur_req = "R2";
        hb_in = 1'b1;
        wait_cyc(2);
        check(1'b0, "R5 still low before clear lands");
        wait_cyc(1);
        check(1'b1, "R2 rising toggle clears");

        cur_req = "R3";
        wait_cyc(T);
        check(1'b0, "R3 expired again");
        hb_in = 1'b0;
        wait_cyc(3);
        check(1'b1, "R3 falling toggle clears");

        cur_req = "R5";
        for (int i = 0; i < 8; i++) begin
            wait_cyc(T - 4);
            hb_in = ~hb_in;
        end
        wait_cyc(2);
        check(1'b1, "R5 regular toggling keeps high");

        cur_req = "R11";
        wait_cyc(T - 4);
        hb_in = ~hb_in;
        wait_cyc(1);
        hb_in = ~hb_in;
        wait_cyc(6);
        check(1'b1, "R11 one-cycle pulse detected");

        cur_req = "R6";
        low_supply = 1'b1;
        #1;
        check(1'b0, "R6 low supply forces low");
        wait_cyc(2);
        cur_req = "R7";
        low_supply = 1'b0;
        #1;
        check(1'b1, "R7 immediate release");
        wait_cyc(T + 2);
        low_supply = 1'b1;
        wait_cyc(2);
        low_supply = 1'b0;
        #1;
        check(1'b0, "R7 timeout still pending after release");

        cur_req = "R4";
        sys_rst = 1'b1;
        wait_cyc(1);
        check(1'b1, "R4 reset clears timed-out counter");
        sys_rst = 1'b0;

        cur_req = "R8";
        wd_en = 1'b0;
        wait_cyc(3 * T);
        check(1'b1, "R8 disabled: no timeout");
        low_supply = 1'b1;
        #1;
        check(1'b0, "R8 disabled: low supply still drives low");
        low_supply = 1'b0;
        #1;
        check(1'b1, "R8 disabled: release");

        cur_req = "R9";
        wd_en = 1'b1;
        wait_cyc(T - 1);
        check(1'b1, "R9 fresh timeout after re-enable");
        wait_cyc(1);
        check(1'b0, "R9 full timeout after re-enable");

        wait_cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        done = 1'b1;
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule